// File: doc/BRIEF.md
# Data Value Watchpoint Unit

This unit watches the data accesses on a processor's load/store bus, whether the access comes from the CPU or from a DMA engine. Two break channels each hold a compare address and a compare data value. An access matches a channel when both its address and its 32-bit bus data equal that channel's values. Bits can be left out of the address compare or the data compare through two shared mask registers, and each mask has its own enable bit. A match sets a sticky per-channel flag. While any flag is set, a single level-sensitive operand-break request goes to the CPU.

On the first match after all flags are clear, the unit captures two addresses. One is the operand address of the access. The other is the address of the instruction that executed just before it, which is normally the instruction that caused the transfer. Both are held until software has cleared every flag, so a later match cannot overwrite the evidence of the first one.

Software reaches the unit through a small synchronous register port, using word addresses 0 to 9. Reads are combinational. Flags are cleared by writing 1 to them. A sub-word operand sits in a byte lane chosen by its address, so software selects the operand length through the data mask. For misaligned halfword and word accesses, the low address bits that the bus ignores are left out of the compare.

Top module: `dv_watch`

## Requirements
- R1: A match can occur only while the mode field CTRL[1:0] (register 0) equals 2'b11. Any other value suppresses all matches.
- R2: Channel 0 compares against DCMP0 (register 3) and ACMP0 (register 4). Channel 1 compares against DCMP1 (register 5) and ACMP1 (register 6). A channel matches only when its enable bit is set: CTRL[2] for channel 0, CTRL[3] for channel 1.
- R3: With CTRL[4] set, the data bits that are set in DMASK (register 1) are ignored. With CTRL[5] set, the address bits that are set in AMASK (register 2) are ignored. With an enable bit clear, its mask has no effect.
- R4: bus_size encodes 00 as byte, 01 as halfword and 10 as word. A halfword access ignores address bit 0 and a word access ignores address bits 1:0 in the compare.
- R5: The size filter is CTRL[9:8]. The value 00 accepts any size, 01 accepts only bytes, 10 only halfwords and 11 only words.
- R6: bus_master = 0 marks a CPU access, which can match only if CTRL[6] is set. bus_master = 1 marks a DMA access, which can match only if CTRL[7] is set.
- R7: A match on channel c sets FLAGS[c] (register 7, bits 1:0) at the next clock edge. A flag stays set until a write to register 7 with a 1 in that bit position. A match in the same cycle as the clear keeps the flag set.
- R8: brk_req is high exactly while any flag is set, so it rises one cycle after a matching access.
- R9: When a match occurs while all flags are clear, the unit captures bus_addr into register 8. In the same cycle it captures into register 9 the instr_addr of the most recent earlier cycle that had instr_valid set. While any flag is set, both registers hold their values.
- R10: After reset every register reads 0. Register 0 reads back bits 9:0, registers 1 to 6 read back all 32 bits, and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 4 | Register word address |
| reg_we | input | 1 | Register write enable |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| bus_valid | input | 1 | A data access is on the bus this cycle |
| bus_master | input | 1 | 0 = CPU access, 1 = DMA access |
| bus_size | input | 2 | Access size: 00 byte, 01 halfword, 10 word |
| bus_addr | input | 32 | Operand address of the access |
| bus_data | input | 32 | 32-bit bus data of the access |
| instr_valid | input | 1 | An instruction executes this cycle |
| instr_addr | input | 32 | Address of that instruction |
| brk_req | output | 1 | Operand-break exception request (level) |

## Verification
The hardest situation to reach from the ports is the one where the capture registers must stay frozen. This happens when a second match arrives on the other channel while the first flag is still pending. It also happens when a match lands in the very cycle that software clears a flag. Random addresses and data almost never equal the compare registers, so the random stimulus is biased. It starts from a channel's compare value and flips only a few low or single bits, and clear writes are mixed in at random times. Directed sequences first build these overlaps explicitly, and then walk the alignment, size and master filters one at a time.

// File: rtl/dv_watch.sv
`timescale 1ns/1ps
module dv_watch (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  reg_addr,
  input  logic        reg_we,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        bus_valid,
  input  logic        bus_master,
  input  logic [1:0]  bus_size,
  input  logic [31:0] bus_addr,
  input  logic [31:0] bus_data,
  input  logic        instr_valid,
  input  logic [31:0] instr_addr,
  output logic        brk_req
);
  localparam int NCH = 2;

  logic [9:0]     ctrl;
  logic [31:0]    dmask, amask;
  logic [31:0]    dcmp [NCH];
  logic [31:0]    acmp [NCH];
  logic [NCH-1:0] flags, hit, clr;
  logic [31:0]    cap_op, cap_ins, prev_ins;

  wire mode_on   = ctrl[1:0] == 2'b11;
  wire master_ok = bus_master ? ctrl[7] : ctrl[6];
  wire size_ok   = (ctrl[9:8] == 2'b00) || (bus_size == ctrl[9:8] - 2'd1);
  wire acc_ok    = bus_valid && mode_on && master_ok && size_ok;

  wire [1:0]  align     = (bus_size == 2'b10) ? 2'b11 : (bus_size == 2'b01) ? 2'b01 : 2'b00;
  wire [31:0] amask_eff = (ctrl[5] ? amask : 32'h0) | {30'h0, align};
  wire [31:0] dmask_eff = ctrl[4] ? dmask : 32'h0;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign hit[c] = acc_ok && ctrl[2+c]
                 && (((bus_addr ^ acmp[c]) & ~amask_eff) == 32'h0)
                 && (((bus_data ^ dcmp[c]) & ~dmask_eff) == 32'h0);
  end

  assign clr     = (reg_we && reg_addr == 4'd7) ? reg_wdata[NCH-1:0] : '0;
  assign brk_req = |flags;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl     <= '0;
      dmask    <= '0;
      amask    <= '0;
      dcmp[0]  <= '0;
      dcmp[1]  <= '0;
      acmp[0]  <= '0;
      acmp[1]  <= '0;
      flags    <= '0;
      cap_op   <= '0;
      cap_ins  <= '0;
      prev_ins <= '0;
    end else begin
      if (reg_we) begin
        case (reg_addr)
          4'd0: ctrl    <= reg_wdata[9:0];
          4'd1: dmask   <= reg_wdata;
          4'd2: amask   <= reg_wdata;
          4'd3: dcmp[0] <= reg_wdata;
          4'd4: acmp[0] <= reg_wdata;
          4'd5: dcmp[1] <= reg_wdata;
          4'd6: acmp[1] <= reg_wdata;
          default: ;
        endcase
      end
      flags <= (flags & ~clr) | hit;
      if ((|hit) && flags == '0) begin
        cap_op  <= bus_addr;
        cap_ins <= prev_ins;
      end
      if (instr_valid) prev_ins <= instr_addr;
    end
  end

  always_comb begin
    case (reg_addr)
      4'd0:    reg_rdata = {22'h0, ctrl};
      4'd1:    reg_rdata = dmask;
      4'd2:    reg_rdata = amask;
      4'd3:    reg_rdata = dcmp[0];
      4'd4:    reg_rdata = acmp[0];
      4'd5:    reg_rdata = dcmp[1];
      4'd6:    reg_rdata = acmp[1];
      4'd7:    reg_rdata = {30'h0, flags};
      4'd8:    reg_rdata = cap_op;
      4'd9:    reg_rdata = cap_ins;
      default: reg_rdata = 32'h0;
    endcase
  end

  a_r1_mode_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[1:0] != 2'b11) |-> (hit == '0));

  a_r6_dma_block: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_master && !ctrl[7]) |-> (hit == '0));

  a_r7_flag0_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[0] && !clr[0]) |=> flags[0]);

  a_r7_flag1_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[1] && !clr[1]) |=> flags[1]);

  a_r8_req_rises: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit) |=> brk_req);

  a_r8_req_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!brk_req && hit == '0) |=> !brk_req);

  a_r9_capture_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (flags != '0) |=> ($stable(cap_op) && $stable(cap_ins)));
endmodule

// File: tb/test_dv_watch.sv
`timescale 1ns/1ps
module test_dv_watch;
  logic        clk = 0, rst_n = 0;
  logic [3:0]  reg_addr = 0;
  logic        reg_we = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic        bus_valid = 0, bus_master = 0;
  logic [1:0]  bus_size = 0;
  logic [31:0] bus_addr = 0, bus_data = 0;
  logic        instr_valid = 0;
  logic [31:0] instr_addr = 0;
  logic        brk_req;

  int nchk = 0, nfail = 0;

  logic [9:0]  m_ctrl = 0;
  logic [31:0] m_dmask = 0, m_amask = 0;
  logic [31:0] m_dcmp [2];
  logic [31:0] m_acmp [2];
  logic [1:0]  m_flags = 0;
  logic [31:0] m_cop = 0, m_cins = 0, m_prev = 0;

  always #5 clk = ~clk;

  dv_watch i_dv_watch (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_valid(bus_valid),
    .bus_master(bus_master), .bus_size(bus_size), .bus_addr(bus_addr),
    .bus_data(bus_data), .instr_valid(instr_valid), .instr_addr(instr_addr),
    .brk_req(brk_req));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [1:0] exp_hit();
    logic [1:0]  h = 2'b00;
    logic [31:0] am, dm;
    if (!bus_valid || m_ctrl[1:0] != 2'b11) return 2'b00;
    if (bus_master ? !m_ctrl[7] : !m_ctrl[6]) return 2'b00;
    if (m_ctrl[9:8] == 2'b01 && bus_size != 2'b00) return 2'b00;
    if (m_ctrl[9:8] == 2'b10 && bus_size != 2'b01) return 2'b00;
    if (m_ctrl[9:8] == 2'b11 && bus_size != 2'b10) return 2'b00;
    am = m_ctrl[5] ? m_amask : 32'h0;
    if (bus_size == 2'b10) am = am | 32'h3;
    else if (bus_size == 2'b01) am = am | 32'h1;
    dm = m_ctrl[4] ? m_dmask : 32'h0;
    for (int c = 0; c < 2; c++)
      if (m_ctrl[2+c] && (((bus_addr ^ m_acmp[c]) & ~am) == 0) && (((bus_data ^ m_dcmp[c]) & ~dm) == 0))
        h[c] = 1'b1;
    return h;
  endfunction

  task automatic cycle();
    logic [1:0] h, c;
    h = exp_hit();
    c = (reg_we && reg_addr == 4'd7) ? reg_wdata[1:0] : 2'b00;
    if (reg_we)
      case (reg_addr)
        4'd0: m_ctrl = reg_wdata[9:0];
        4'd1: m_dmask = reg_wdata;
        4'd2: m_amask = reg_wdata;
        4'd3: m_dcmp[0] = reg_wdata;
        4'd4: m_acmp[0] = reg_wdata;
        4'd5: m_dcmp[1] = reg_wdata;
        4'd6: m_acmp[1] = reg_wdata;
        default: ;
      endcase
    if (h != 0 && m_flags == 0) begin m_cop = bus_addr; m_cins = m_prev; end
    m_flags = (m_flags & ~c) | h;
    if (instr_valid) m_prev = instr_addr;
    @(negedge clk);
    chk(brk_req === (m_flags != 0), "R8 brk_req", {31'h0, brk_req}, {31'h0, m_flags != 0});
    reg_we = 0;
    bus_valid = 0;
    instr_valid = 0;
  endtask

  task automatic acc(input logic m, input logic [1:0] s, input logic [31:0] a, input logic [31:0] d);
    bus_valid = 1; bus_master = m; bus_size = s; bus_addr = a; bus_data = d;
    instr_valid = 1; instr_addr = $urandom & 32'hFFFF_FFFC;
    cycle();
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    instr_valid = $urandom % 2; instr_addr = $urandom;
    cycle();
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
    reg_addr = a;
    #1;
    chk(reg_rdata === exp, tag, reg_rdata, exp);
  endtask

  task automatic rd_state(input string tag);
    rd(4'd7, {30'h0, m_flags}, {tag, " flags"});
    rd(4'd8, m_cop, {tag, " cap_op"});
    rd(4'd9, m_cins, {tag, " cap_ins"});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired, actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    m_dcmp[0] = 0; m_dcmp[1] = 0; m_acmp[0] = 0; m_acmp[1] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk(brk_req === 1'b0, "R8 reset brk_req", {31'h0, brk_req}, 32'h0);
    for (int a = 0; a < 11; a++) rd(4'(a), 32'h0, "R10 reset value");

    wr(4'd3, 32'hDEADBEEF); wr(4'd4, 32'h1000);
    wr(4'd5, 32'h12345678); wr(4'd6, 32'h2000);
    wr(4'd0, 32'h4E);
    rd(4'd0, 32'h4E, "R10 ctrl readback");
    rd(4'd6, 32'h2000, "R10 acmp1 readback");
    acc(0, 2'b10, 32'h1000, 32'hDEADBEEF);
    chk(brk_req === 1'b0, "R1 mode 10 blocks", {31'h0, brk_req}, 32'h0);
    wr(4'd0, 32'h4F);
    acc(0, 2'b10, 32'h1000, 32'hDEADBEEF);
    chk(brk_req === 1'b1, "R1 mode 11 hit", {31'h0, brk_req}, 32'h1);
    rd(4'd7, 32'h1, "R7 flag0 set");
    rd(4'd8, 32'h1000, "R9 cap_op");
    rd(4'd9, m_cins, "R9 cap_ins");
    acc(0, 2'b10, 32'h2000, 32'h12345678);
    rd(4'd7, 32'h3, "R7 flag1 set");
    rd(4'd8, 32'h1000, "R9 cap_op held");
    wr(4'd7, 32'h1);
    rd(4'd7, 32'h2, "R7 partial clear");
    chk(brk_req === 1'b1, "R8 still pending", {31'h0, brk_req}, 32'h1);
    wr(4'd7, 32'h2);
    chk(brk_req === 1'b0, "R8 cleared", {31'h0, brk_req}, 32'h0);

    wr(4'd0, 32'h47);
    acc(0, 2'b10, 32'h2000, 32'h12345678);
    chk(brk_req === 1'b0, "R2 ch1 disabled", {31'h0, brk_req}, 32'h0);
    acc(0, 2'b10, 32'h2000, 32'hDEADBEEF);
    chk(brk_req === 1'b0, "R2 cross-channel pair", {31'h0, brk_req}, 32'h0);

    acc(0, 2'b10, 32'h1003, 32'hDEADBEEF);
    chk(brk_req === 1'b1, "R4 word ignores a[1:0]", {31'h0, brk_req}, 32'h1);
    wr(4'd7, 32'h3);
    acc(0, 2'b01, 32'h1003, 32'hDEADBEEF);
    chk(brk_req === 1'b0, "R4 half keeps a[1]", {31'h0, brk_req}, 32'h0);
    acc(0, 2'b01, 32'h1001, 32'hDEADBEEF);
    chk(brk_req === 1'b1, "R4 half ignores a[0]", {31'h0, brk_req}, 32'h1);
    wr(4'd7, 32'h3);
    acc(0, 2'b00, 32'h1001, 32'hDEADBEEF);
    chk(brk_req === 1'b0, "R4 byte exact", {31'h0, brk_req}, 32'h0);

    wr(4'd1, 32'hFF);
    acc(0, 2'b10, 32'h1000, 32'hDEADBE00);
    chk(brk_req === 1'b0, "R3 dmask disabled", {31'h0, brk_req}, 32'h0);
    wr(4'd0, 32'h57);
    acc(0, 2'b10, 32'h1000, 32'hDEADBE00);
    chk(brk_req === 1'b1, "R3 dmask enabled", {31'h0, brk_req}, 32'h1);
    wr(4'd7, 32'h3);
    wr(4'd2, 32'hF0);
    acc(0, 2'b10, 32'h1040, 32'hDEADBEEF);
    chk(brk_req === 1'b0, "R3 amask disabled", {31'h0, brk_req}, 32'h0);
    wr(4'd0, 32'h77);
    acc(0, 2'b10, 32'h1040, 32'hDEADBEEF);
    chk(brk_req === 1'b1, "R3 amask enabled", {31'h0, brk_req}, 32'h1);
    wr(4'd7, 32'h3);

    wr(4'd0, 32'h147);
    acc(0, 2'b10, 32'h1000, 32'hDEADBEEF);
    chk(brk_req === 1'b0, "R5 byte-only rejects word", {31'h0, brk_req}, 32'h0);
    acc(0, 2'b00, 32'h1000, 32'hDEADBEEF);
    chk(brk_req === 1'b1, "R5 byte-only accepts byte", {31'h0, brk_req}, 32'h1);
    wr(4'd7, 32'h3);
    wr(4'd0, 32'h347);
    acc(0, 2'b01, 32'h1000, 32'hDEADBEEF);
    chk(brk_req === 1'b0, "R5 word-only rejects half", {31'h0, brk_req}, 32'h0);

    wr(4'd0, 32'h47);
    acc(1, 2'b10, 32'h1000, 32'hDEADBEEF);
    chk(brk_req === 1'b0, "R6 dma blocked", {31'h0, brk_req}, 32'h0);
    wr(4'd0, 32'h87);
    acc(0, 2'b10, 32'h1000, 32'hDEADBEEF);
    chk(brk_req === 1'b0, "R6 cpu blocked", {31'h0, brk_req}, 32'h0);
    acc(1, 2'b10, 32'h1000, 32'hDEADBEEF);
    chk(brk_req === 1'b1, "R6 dma allowed", {31'h0, brk_req}, 32'h1);
    rd_state("R9 dma capture");

    reg_we = 1; reg_addr = 4'd7; reg_wdata = 32'h1;
    bus_valid = 1; bus_master = 1; bus_size = 2'b10; bus_addr = 32'h1000; bus_data = 32'hDEADBEEF;
    cycle();
    rd(4'd7, 32'h1, "R7 set beats clear");
    wr(4'd7, 32'h1);
    rd(4'd7, 32'h0, "R7 cleared");
    wr(4'd0, 32'hCF);
    acc(0, 2'b10, 32'h2000, 32'h12345678);
    rd_state("R9 fresh capture");

    for (int i = 0; i < 4000; i++) begin
      int op = $urandom % 20;
      if (op == 0) begin
        logic [31:0] v = ($urandom & 32'h3FF) | ((($urandom % 4) != 0) ? 32'h3 : 32'h0);
        wr(4'd0, v);
      end else if (op == 1) begin
        wr(4'd1 + 4'($urandom % 2), ($urandom % 2) ? (32'h1 << ($urandom % 32)) : 32'hF);
      end else if (op == 2 || op == 3) begin
        wr(4'd7, $urandom % 4);
      end else begin
        int c = $urandom % 2;
        logic [31:0] a = m_acmp[c], d = m_dcmp[c];
        if ($urandom % 4 == 0) a = a ^ (32'h1 << ($urandom % 32)); else a = a ^ ($urandom % 4);
        if ($urandom % 4 == 0) d = d ^ (32'h1 << ($urandom % 32));
        acc($urandom % 2, 2'($urandom % 3), a, d);
      end
      if (i % 16 == 15) rd_state("R7 R9 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule